// File: doc/BRIEF.md
# Interrupt Request Latch with Acknowledge

This block keeps the per-line state of an eight-input interrupt controller. It resynchronizes each raw request pin, records pending requests and the last sampled level of each line, and holds the in-service bits and the priority rotation offset. The control logic around it uses these registers. A priority resolver reads the pending, in-service and offset outputs. End-of-interrupt commands clear in-service bits or load the offset through dedicated update inputs. The acknowledge cycle reports which line is being serviced.

Each line is edge or level triggered. A per-line trigger-select register picks the mode, and a global level-mode bit overrides all lines to level. An acknowledge pulse carries a line number. The latch then either marks that line in service, or, with automatic end-of-interrupt enabled, leaves in-service alone and can rotate the priority offset to just past the acknowledged line. Only edge-triggered lines lose their pending bit on acknowledge.

Top module: `irq_req_latch`

## Requirements
- R1: A line is level triggered when the global level-mode bit is 1 or its bit in the trigger-select register is 1 (bit i governs line i). Otherwise it is edge triggered. Both registers are loaded by their write strobes one cycle after the strobe.
- R2: For a level-triggered line, the pending bit equals the synchronized input level and falls when the input falls.
- R3: For an edge-triggered line, the pending bit is set when the synchronized input is 1 while the line's previous-level bit is 0. It stays set when the input falls or stays high, until an acknowledge clears it.
- R4: The previous-level bit of every line tracks the synchronized input. A change on a request pin reaches the pending and previous-level outputs SYNC_STAGES+1 clock edges later.
- R5: An acknowledge with automatic end-of-interrupt off sets the in-service bit of the acknowledged line on the next edge.
- R6: An acknowledge with automatic end-of-interrupt on leaves in-service unchanged. If rotate-on-auto-EOI is also on, the offset becomes (line+1) mod NUM_LINES. Otherwise the offset is kept.
- R7: An acknowledge clears the pending bit of the acknowledged line only if that line is edge triggered. A level line stays pending while its input is high.
- R8: When a new edge and an acknowledge of the same line fall into the same cycle, the input update is applied first and the acknowledge then clears it, so the line ends not pending with previous-level 1.
- R9: A synchronous active-low reset clears the synchronizers, the pending, previous-level, in-service, offset and trigger-select registers, and the global level-mode, auto-EOI and rotate bits.
- R10: Each 1 bit in the in-service clear mask clears that in-service bit on the next edge. An acknowledge setting the same bit in the same cycle wins.
- R11: An offset write loads the offset on the next edge. A rotating acknowledge in the same cycle overrides the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | NUM_LINES | Raw request pins, asynchronous |
| ctl_wr_en | input | 1 | Load the three mode bits below |
| ctl_level_all | input | 1 | Global level-mode value |
| ctl_auto_eoi | input | 1 | Automatic end-of-interrupt value |
| ctl_rotate_aeoi | input | 1 | Rotate-on-auto-EOI value |
| trig_wr_en | input | 1 | Load the trigger-select register |
| trig_wr_data | input | NUM_LINES | Trigger-select value, 1 = level |
| ack_valid | input | 1 | Acknowledge pulse |
| ack_line | input | LINE_W | Acknowledged line number |
| isr_clr_mask | input | NUM_LINES | In-service bits to clear this cycle |
| ofs_wr_en | input | 1 | Load the rotation offset |
| ofs_wr_data | input | LINE_W | New rotation offset |
| pend_o | output | NUM_LINES | Pending request register |
| prev_o | output | NUM_LINES | Previous-level register |
| insvc_o | output | NUM_LINES | In-service register |
| trig_o | output | NUM_LINES | Trigger-select register |
| ofs_o | output | LINE_W | Rotation offset |
| level_all_o | output | 1 | Global level-mode bit |
| auto_eoi_o | output | 1 | Automatic end-of-interrupt bit |
| rotate_aeoi_o | output | 1 | Rotate-on-auto-EOI bit |

## Verification
The bench builds the block with its defaults: eight lines and a two-flop synchronizer. With these, the rotation wrap from line 7 to offset 0 can be reached, and the exact pin-to-register latency of three edges can be timed. With the trigger-select register split into four edge lines and four level lines, one input pattern exercises both pending rules side by side. The same cycle count lets the bench land a new edge exactly on an acknowledge, and drive offset writes and in-service clears in the same cycle as acknowledges.

// File: rtl/irq_latch_pkg.sv
// Package: shared helpers for the interrupt request latch.
// Assumes line counts of at least two.
package irq_latch_pkg;

    // Mode bits held by the configuration register.
    typedef struct packed {
        logic level_all;
        logic auto_eoi;
        logic rotate_aeoi;
    } latch_ctl_t;

    // Next line after 'line', wrapping at 'count'.
    function automatic int wrap_next(input int line, input int count);
        return (line + 1 >= count) ? 0 : line + 1;
    endfunction

endpackage

// File: rtl/irq_sync.sv
// Module: irq_sync
// Multi-flop synchronizer for a vector of asynchronous request pins.
// Assumes STAGES >= 1. Reset drives every stage to 0.
module irq_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            // Shift each pin level one flop further per clock.
            always_ff @(posedge clk) begin
                if (!rst_n)      stage_q[s] <= '0;
                else if (s == 0) stage_q[s] <= async_in;
                else             stage_q[s] <= stage_q[(s > 0) ? s - 1 : 0];
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/irq_cfg_regs.sv
// Module: irq_cfg_regs
// Holds the trigger-select register and the mode bits. A line's effective
// level-trigger flag is its trigger bit OR the global level-mode bit.
// Assumes writes are single-cycle strobes.
module irq_cfg_regs
    import irq_latch_pkg::*;
#(
    parameter int NUM_LINES = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ctl_wr_en,
    input  latch_ctl_t           ctl_wr_data,
    input  logic                 trig_wr_en,
    input  logic [NUM_LINES-1:0] trig_wr_data,
    output latch_ctl_t           ctl_q,
    output logic [NUM_LINES-1:0] trig_q,
    output logic [NUM_LINES-1:0] is_level
);
    // Load the mode bits on their strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)         ctl_q <= '0;
        else if (ctl_wr_en) ctl_q <= ctl_wr_data;
    end

    // Load the trigger-select register on its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)          trig_q <= '0;
        else if (trig_wr_en) trig_q <= trig_wr_data;
    end

    // Effective trigger mode per line.
    always_comb begin
        is_level = trig_q | {NUM_LINES{ctl_q.level_all}};
    end

    // R1: after a trigger write, lines written 1 are level triggered.
    p_trig_level_r1: assert property (@(posedge clk) disable iff (!rst_n)
        trig_wr_en |=> ((is_level & $past(trig_wr_data)) == $past(trig_wr_data)));
endmodule

// File: rtl/irq_line_cell.sv
// Module: irq_line_cell
// Pending and previous-level state of one request line. The input update is
// applied before an acknowledge in the same cycle.
// Assumes sync_in is already synchronized to clk.
module irq_line_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_in,
    input  logic is_level,
    input  logic ack_hit,
    output logic pend_q,
    output logic prev_q
);
    logic pend_after_in;
    logic pend_next;

    // Pending rule for the line's current trigger mode, then the acknowledge.
    always_comb begin
        if (is_level) pend_after_in = sync_in;
        else          pend_after_in = pend_q | (sync_in & ~prev_q);
        pend_next = (ack_hit && !is_level) ? 1'b0 : pend_after_in;
    end

    // Register pending and previous-level state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            pend_q <= pend_next;
            prev_q <= sync_in;
        end
    end

    // R3: a rising edge on an edge line raises pending.
    p_edge_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_level && sync_in && !prev_q && !ack_hit) |=> pend_q);
    // R3: an edge line stays pending until acknowledged.
    p_edge_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_level && pend_q && !ack_hit) |=> pend_q);
    // R2: a level line's pending bit matches its sampled level.
    p_level_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        is_level |=> (pend_q == prev_q));
    // R7: acknowledge empties an edge line's pending bit.
    p_ack_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_hit && !is_level) |=> !pend_q);
endmodule

// File: rtl/irq_insvc.sv
// Module: irq_insvc
// In-service register and priority rotation offset. Clears from the mask
// apply before an acknowledge set; a rotating acknowledge beats an offset write.
// Assumes ack_line < NUM_LINES.
module irq_insvc
    import irq_latch_pkg::*;
#(
    parameter int NUM_LINES = 8,
    parameter int LINE_W    = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ack_valid,
    input  logic [LINE_W-1:0]    ack_line,
    input  logic [NUM_LINES-1:0] ack_hot,
    input  logic                 auto_eoi,
    input  logic                 rotate_aeoi,
    input  logic [NUM_LINES-1:0] clr_mask,
    input  logic                 ofs_wr_en,
    input  logic [LINE_W-1:0]    ofs_wr_data,
    output logic [NUM_LINES-1:0] isr_q,
    output logic [LINE_W-1:0]    ofs_q
);
    logic [NUM_LINES-1:0] isr_next;
    logic [LINE_W-1:0]    ofs_next;
    logic [LINE_W-1:0]    rot_target;

    // Next in-service value and next offset.
    always_comb begin
        rot_target = LINE_W'(wrap_next(int'(ack_line), NUM_LINES));
        isr_next   = isr_q & ~clr_mask;
        if (ack_valid && !auto_eoi) isr_next = isr_next | ack_hot;
        ofs_next = ofs_q;
        if (ofs_wr_en) ofs_next = ofs_wr_data;
        if (ack_valid && auto_eoi && rotate_aeoi) ofs_next = rot_target;
    end

    // Register in-service bits and offset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            isr_q <= '0;
            ofs_q <= '0;
        end else begin
            isr_q <= isr_next;
            ofs_q <= ofs_next;
        end
    end

    // R5: a plain acknowledge marks its line in service.
    p_ack_isr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && !auto_eoi) |=> isr_q[$past(ack_line)]);
    // R6: automatic end-of-interrupt leaves in-service untouched.
    p_aeoi_isr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && auto_eoi && clr_mask == '0) |=> $stable(isr_q));
    // R6: rotation lands just past the acknowledged line.
    p_rotate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && auto_eoi && rotate_aeoi) |=>
        (int'(ofs_q) == (int'($past(ack_line)) + 1) % NUM_LINES));
    // R11: an offset write alone is taken.
    p_ofs_wr_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ofs_wr_en && !(ack_valid && auto_eoi && rotate_aeoi)) |=> (ofs_q == $past(ofs_wr_data)));
endmodule

// File: rtl/irq_req_latch.sv
// Module: irq_req_latch
// Top of the interrupt request latch: synchronizer, configuration, one
// cell per line and the in-service/offset register.
// Assumes ack_line addresses an existing line.
module irq_req_latch
    import irq_latch_pkg::*;
#(
    parameter int NUM_LINES   = 8,
    parameter int SYNC_STAGES = 2,
    localparam int LINE_W     = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic                 ctl_wr_en,
    input  logic                 ctl_level_all,
    input  logic                 ctl_auto_eoi,
    input  logic                 ctl_rotate_aeoi,
    input  logic                 trig_wr_en,
    input  logic [NUM_LINES-1:0] trig_wr_data,
    input  logic                 ack_valid,
    input  logic [LINE_W-1:0]    ack_line,
    input  logic [NUM_LINES-1:0] isr_clr_mask,
    input  logic                 ofs_wr_en,
    input  logic [LINE_W-1:0]    ofs_wr_data,
    output logic [NUM_LINES-1:0] pend_o,
    output logic [NUM_LINES-1:0] prev_o,
    output logic [NUM_LINES-1:0] insvc_o,
    output logic [NUM_LINES-1:0] trig_o,
    output logic [LINE_W-1:0]    ofs_o,
    output logic                 level_all_o,
    output logic                 auto_eoi_o,
    output logic                 rotate_aeoi_o
);
    logic [NUM_LINES-1:0] sync_lvl;
    logic [NUM_LINES-1:0] is_level;
    logic [NUM_LINES-1:0] ack_hot;
    latch_ctl_t           ctl_wr;
    latch_ctl_t           ctl_q;

    // Pack the mode write and decode the acknowledged line.
    always_comb begin
        ctl_wr.level_all   = ctl_level_all;
        ctl_wr.auto_eoi    = ctl_auto_eoi;
        ctl_wr.rotate_aeoi = ctl_rotate_aeoi;
        ack_hot = ack_valid ? (NUM_LINES'(1) << ack_line) : '0;
    end

    irq_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(irq_in), .sync_out(sync_lvl)
    );

    irq_cfg_regs #(.NUM_LINES(NUM_LINES)) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr),
        .trig_wr_en(trig_wr_en), .trig_wr_data(trig_wr_data),
        .ctl_q(ctl_q), .trig_q(trig_o), .is_level(is_level)
    );

    genvar i;
    generate
        for (i = 0; i < NUM_LINES; i++) begin : g_line
            irq_line_cell u_cell (
                .clk(clk), .rst_n(rst_n),
                .sync_in(sync_lvl[i]), .is_level(is_level[i]),
                .ack_hit(ack_hot[i]),
                .pend_q(pend_o[i]), .prev_q(prev_o[i])
            );
        end
    endgenerate

    irq_insvc #(.NUM_LINES(NUM_LINES), .LINE_W(LINE_W)) u_insvc (
        .clk(clk), .rst_n(rst_n),
        .ack_valid(ack_valid), .ack_line(ack_line), .ack_hot(ack_hot),
        .auto_eoi(ctl_q.auto_eoi), .rotate_aeoi(ctl_q.rotate_aeoi),
        .clr_mask(isr_clr_mask),
        .ofs_wr_en(ofs_wr_en), .ofs_wr_data(ofs_wr_data),
        .isr_q(insvc_o), .ofs_q(ofs_o)
    );

    // Bring the mode bits out.
    always_comb begin
        level_all_o   = ctl_q.level_all;
        auto_eoi_o    = ctl_q.auto_eoi;
        rotate_aeoi_o = ctl_q.rotate_aeoi;
    end

    // R4: previous-level register follows the synchronizer one edge later.
    p_prev_track_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ##1 1'b1 |-> (prev_o == $past(sync_lvl)));
    // R9: reset leaves the mode bits cleared.
    p_reset_mode_r9: assert property (@(posedge clk)
        $past(!rst_n) |-> (!level_all_o && !auto_eoi_o && !rotate_aeoi_o && trig_o == '0));
endmodule

// File: tb/tb_irq_req_latch.sv
module tb_irq_req_latch;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 8;
    localparam int LW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  irq_in = '0;
    logic          ctl_wr_en = 1'b0, ctl_level_all = 1'b0, ctl_auto_eoi = 1'b0, ctl_rotate_aeoi = 1'b0;
    logic          trig_wr_en = 1'b0;
    logic [N-1:0]  trig_wr_data = '0;
    logic          ack_valid = 1'b0;
    logic [LW-1:0] ack_line = '0;
    logic [N-1:0]  isr_clr_mask = '0;
    logic          ofs_wr_en = 1'b0;
    logic [LW-1:0] ofs_wr_data = '0;
    logic [N-1:0]  pend_o, prev_o, insvc_o, trig_o;
    logic [LW-1:0] ofs_o;
    logic          level_all_o, auto_eoi_o, rotate_aeoi_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    irq_req_latch dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .ctl_wr_en(ctl_wr_en), .ctl_level_all(ctl_level_all),
        .ctl_auto_eoi(ctl_auto_eoi), .ctl_rotate_aeoi(ctl_rotate_aeoi),
        .trig_wr_en(trig_wr_en), .trig_wr_data(trig_wr_data),
        .ack_valid(ack_valid), .ack_line(ack_line),
        .isr_clr_mask(isr_clr_mask),
        .ofs_wr_en(ofs_wr_en), .ofs_wr_data(ofs_wr_data),
        .pend_o(pend_o), .prev_o(prev_o), .insvc_o(insvc_o), .trig_o(trig_o),
        .ofs_o(ofs_o), .level_all_o(level_all_o), .auto_eoi_o(auto_eoi_o),
        .rotate_aeoi_o(rotate_aeoi_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Table: {irq_in, expected pending, expected previous-level},
    // lines 7..4 level, 3..0 edge.
    localparam logic [23:0] VEC [0:5] = '{
        {8'h11, 8'h11, 8'h11},
        {8'h00, 8'h01, 8'h00},
        {8'h22, 8'h23, 8'h22},
        {8'h22, 8'h23, 8'h22},
        {8'hFF, 8'hFF, 8'hFF},
        {8'h0F, 8'h0F, 8'h0F}
    };

    task automatic tick(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_ctl(input logic lvl, input logic aeoi, input logic rot);
        ctl_wr_en = 1'b1; ctl_level_all = lvl; ctl_auto_eoi = aeoi; ctl_rotate_aeoi = rot;
        tick(1);
        ctl_wr_en = 1'b0;
    endtask

    task automatic ack(input logic [LW-1:0] line);
        ack_valid = 1'b1; ack_line = line;
        tick(1);
        ack_valid = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        tick(3);
        // R9: reset state
        check("R9 pend", 32'(pend_o), 0);
        check("R9 insvc", 32'(insvc_o), 0);
        check("R9 ofs", 32'(ofs_o), 0);
        rst_n = 1'b1;
        tick(1);

        trig_wr_en = 1'b1; trig_wr_data = 8'hF0;
        tick(1);
        trig_wr_en = 1'b0;
        check("R1 trig write", 32'(trig_o), 32'hF0);

        // R2 R3 R4 table walk, three edges from pin to register
        for (int v = 0; v < 6; v++) begin
            irq_in = VEC[v][23:16];
            tick(3);
            check("R2/R3 pend vector", 32'(pend_o), 32'(VEC[v][15:8]));
            check("R4 prev vector", 32'(prev_o), 32'(VEC[v][7:0]));
        end

        // R5 R7: plain ack on edge line 2
        ack(3'd2);
        check("R5 isr set", 32'(insvc_o), 32'h04);
        check("R7 edge pend cleared", 32'(pend_o), 32'h0B);
        tick(3);
        check("R3 no rearm while high", 32'(pend_o), 32'h0B);

        // R7: ack on level line 4 keeps pending
        irq_in = 8'h1F;
        tick(3);
        ack(3'd4);
        check("R7 level stays pending", 32'(pend_o), 32'h1B);
        check("R5 isr line4", 32'(insvc_o), 32'h14);

        // R10: clear mask, then clear and set together
        isr_clr_mask = 8'h04; tick(1); isr_clr_mask = '0;
        check("R10 isr clear", 32'(insvc_o), 32'h10);
        isr_clr_mask = 8'h10; ack_valid = 1'b1; ack_line = 3'd4;
        tick(1);
        isr_clr_mask = '0; ack_valid = 1'b0;
        check("R10 ack set wins", 32'(insvc_o), 32'h10);
        isr_clr_mask = 8'h10; tick(1); isr_clr_mask = '0;
        check("R10 isr empty", 32'(insvc_o), 0);

        // R6: auto-EOI with rotate, wrap at the top line
        write_ctl(1'b0, 1'b1, 1'b1);
        ack(3'd7);
        check("R6 rotate wrap", 32'(ofs_o), 0);
        check("R6 isr untouched", 32'(insvc_o), 0);
        ack(3'd3);
        check("R6 rotate line3", 32'(ofs_o), 4);
        check("R7 aeoi edge clear", 32'(pend_o), 32'h13);

        // R6: auto-EOI without rotate keeps the offset
        write_ctl(1'b0, 1'b1, 1'b0);
        ack(3'd0);
        check("R6 no rotate", 32'(ofs_o), 4);
        check("R6 pend line0 clear", 32'(pend_o), 32'h12);

        // R11: offset write, then write against rotation
        ofs_wr_en = 1'b1; ofs_wr_data = 3'd2; tick(1); ofs_wr_en = 1'b0;
        check("R11 offset write", 32'(ofs_o), 2);
        write_ctl(1'b0, 1'b1, 1'b1);
        ofs_wr_en = 1'b1; ofs_wr_data = 3'd1; ack_valid = 1'b1; ack_line = 3'd5;
        tick(1);
        ofs_wr_en = 1'b0; ack_valid = 1'b0;
        check("R11 rotation wins", 32'(ofs_o), 6);

        // R1 R2: global level mode turns edge lines into level lines
        write_ctl(1'b1, 1'b0, 1'b0);
        check("R1 level_all set", 32'(level_all_o), 1);
        tick(1);
        check("R1 all follow input", 32'(pend_o), 32'h1F);
        irq_in = 8'h00;
        tick(3);
        check("R2 all drop", 32'(pend_o), 0);
        write_ctl(1'b0, 1'b0, 1'b0);

        // R8: edge and ack in the same cycle on line 0
        irq_in = 8'h01;
        tick(2);
        ack(3'd0);
        check("R8 pend cleared", 32'(pend_o), 0);
        check("R8 prev set", 32'(prev_o), 32'h01);
        check("R8 isr set", 32'(insvc_o), 32'h01);

        // R9: reset clears configuration
        write_ctl(1'b1, 1'b1, 1'b1);
        rst_n = 1'b0;
        tick(2);
        check("R9 trig cleared", 32'(trig_o), 0);
        check("R9 mode cleared", 32'({level_all_o, auto_eoi_o, rotate_aeoi_o}), 0);
        check("R9 isr/prev cleared", 32'({insvc_o, prev_o}), 0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule